// File: doc/BRIEF.md
# Trap Entry State Unit

This block computes the architectural register updates a windowed-register processor makes when it enters a trap at privileged level. The surrounding core presents its current state on the inputs: trap level, fetch PC and next PC, processor status word, hyperprivileged status word, condition codes, address-space identifier, window pointer, available-save count and global level. It then pulses a one-cycle trap strobe with the trap type. One cycle later the block presents the raised trap level, the packed saved-state word, the saved PCs, the saved hyperprivileged word, the trap type and the rewritten status word. It also presents the new global level and the new window pointer, with a write pulse that tells the core to commit them.

For window spill and fill traps the block also redirects fetch. The new PC, next PC and next-next PC point at consecutive instructions of a handler block. The fill handler sits at the handler base address and the spill handler 32 instructions above it. The window pointer moves by an amount chosen from the trap-type range, and all window arithmetic wraps modulo the number of windows, which need not be a power of two.

A small state machine guards the trap level. It has two states. `ST_RUN` is the normal state: a strobe with room left in the trap level takes the "take" transition back to `ST_RUN`. A strobe at the maximum trap level takes the "overflow" transition to `ST_FAULT`. In `ST_FAULT` the "hold" transition keeps the machine there, and every strobe is ignored. Only reset leaves `ST_FAULT`.

Top module: `trap_entry_unit`

## Requirements
- R1: A strobe taken in `ST_RUN` with `tl_i` below `MAX_TL` gives, one cycle later, `wr_o` = 1 for one cycle and `tl_o` = `tl_i` + 1.
- R2: `tstate_o` holds the global level in bits 42:40, condition codes in 39:32, address-space identifier in 31:24, the 13-bit status word in 20:8 and the window pointer in 4:0, all sampled at the strobe; every other bit is 0.
- R3: `tpc_o` receives `pc_i`, `tnpc_o` receives `npc_i`, `htstate_o` receives `hpsw_i`, and `tt_o` receives `tt_i`.
- R4: `psw_o` equals `psw_i` with bit 4 set, bit 3 cleared, bit 2 set and bit 1 cleared, and with bit 9 copied from bit 8; all other bits pass through unchanged.
- R5: `gl_o` is `gl_i` + 1, saturated at `MAX_GL`.
- R6: Trap type 0x024 gives `cwp_o` = (`cwp_i` + 1) mod `NWIN`.
- R7: Trap types 0x080 to 0x0BF (spill) give `cwp_o` = (`cwp_i` + `cansave_i` + 2) mod `NWIN`.
- R8: Trap types 0x0C0 to 0x0FF (fill) give `cwp_o` = (`cwp_i` − 1) mod `NWIN`, so 0 wraps to `NWIN` − 1.
- R9: Any other trap type gives `cwp_o` = `cwp_i`, and `redir_o` = 0.
- R10: On a spill or fill trap `redir_o` = 1 with `wr_o`. `pc_o` is the handler base for fill and the base + 128 for spill. `npc_o` = `pc_o` + 4 and `nnpc_o` = `pc_o` + 8.
- R11: A strobe in `ST_RUN` with `tl_i` = `MAX_TL` produces no `wr_o` and sets `err_o`. `err_o` stays set, and later strobes produce no `wr_o` and leave `tl_o` unchanged.
- R12: After reset `wr_o`, `redir_o`, `err_o`, `tl_o` and `cwp_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | One-cycle trap strobe |
| tt_i | input | 9 | Trap type |
| tl_i | input | TL_W | Current trap level |
| pc_i | input | ADDR_W | Current PC |
| npc_i | input | ADDR_W | Current next PC |
| psw_i | input | 13 | Current processor status word |
| hpsw_i | input | HPS_W | Current hyperprivileged status word |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address-space identifier |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Available-save count |
| gl_i | input | 3 | Current global level |
| wr_o | output | 1 | Commit pulse for all update outputs |
| tl_o | output | TL_W | New trap level |
| tstate_o | output | 64 | Packed saved-state word |
| tpc_o | output | ADDR_W | Saved PC |
| tnpc_o | output | ADDR_W | Saved next PC |
| htstate_o | output | HPS_W | Saved hyperprivileged word |
| tt_o | output | 9 | Saved trap type |
| psw_o | output | 13 | New processor status word |
| gl_o | output | 3 | New global level |
| cwp_o | output | CWP_W | New window pointer |
| redir_o | output | 1 | Fetch redirect valid |
| pc_o | output | ADDR_W | Redirected PC |
| npc_o | output | ADDR_W | Redirected next PC |
| nnpc_o | output | ADDR_W | Redirected next-next PC |
| err_o | output | 1 | Trap-level overflow error state |

## Verification
The bench builds the block with `NWIN` = 6, `MAX_TL` = 4 and `MAX_GL` = 3. Six windows is not a power of two, so a modulo that is really a bit truncation shows up both when a spill jump wraps past the top and when a fill wraps below zero. The low trap-level ceiling makes the overflow reachable in a handful of traps, along with the stickiness of the fault state. The low global-level cap lets the bench check saturation against a non-saturating case.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int TT_W   = 9;
    localparam int GL_W   = 3;
    localparam int CCR_W  = 8;
    localparam int ASI_W  = 8;
    localparam int PSW_W  = 13;
    localparam int SAVE_W = 64;

    localparam logic [TT_W-1:0] TT_CLEAN   = 9'h024;
    localparam logic [TT_W-1:0] TT_SPILL_L = 9'h080;
    localparam logic [TT_W-1:0] TT_SPILL_H = 9'h0BF;
    localparam logic [TT_W-1:0] TT_FILL_L  = 9'h0C0;
    localparam logic [TT_W-1:0] TT_FILL_H  = 9'h0FF;

    typedef enum logic [0:0] {ST_RUN, ST_FAULT} guard_state_e;

    typedef enum logic [1:0] {WK_NONE, WK_CLEAN, WK_SPILL, WK_FILL} win_kind_e;

    function automatic win_kind_e classify_tt(input logic [TT_W-1:0] tt);
        if (tt == TT_CLEAN)                          return WK_CLEAN;
        else if (tt >= TT_SPILL_L && tt <= TT_SPILL_H) return WK_SPILL;
        else if (tt >= TT_FILL_L && tt <= TT_FILL_H)   return WK_FILL;
        else                                         return WK_NONE;
    endfunction

endpackage

// File: rtl/trap_win_step.sv
module trap_win_step
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  win_kind_e        kind_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam int SUM_W = CWP_W + 2;
    localparam logic [SUM_W-1:0] NW = SUM_W'(NWIN);

    logic [SUM_W-1:0] cwp_x;
    logic [SUM_W-1:0] cs_x;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    assign cwp_x = SUM_W'(cwp_i);
    assign cs_x  = SUM_W'(cansave_i);

    always_comb begin
        unique case (kind_i)
            WK_CLEAN: sum = cwp_x + SUM_W'(1);
            WK_SPILL: sum = cwp_x + cs_x + SUM_W'(2);
            WK_FILL:  sum = cwp_x + NW - SUM_W'(1);
            default:  sum = cwp_x;
        endcase
        rem   = sum % NW;
        cwp_o = rem[CWP_W-1:0];
    end
endmodule

// File: rtl/trap_psw_xform.sv
module trap_psw_xform
    import trap_pkg::*;
(
    input  logic [PSW_W-1:0] psw_i,
    output logic [PSW_W-1:0] psw_o
);
    always_comb begin
        psw_o    = psw_i;
        psw_o[4] = 1'b1;      // floating-point enable
        psw_o[3] = 1'b0;      // address mask off
        psw_o[2] = 1'b1;      // privileged
        psw_o[1] = 1'b0;      // interrupts off
        psw_o[9] = psw_i[8];  // data endianness follows trap endianness
    end
endmodule

// File: rtl/trap_save_pack.sv
module trap_save_pack
    import trap_pkg::*;
#(
    parameter int CWP_W = 3
) (
    input  logic [GL_W-1:0]   gl_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [ASI_W-1:0]  asi_i,
    input  logic [PSW_W-1:0]  psw_i,
    input  logic [CWP_W-1:0]  cwp_i,
    output logic [SAVE_W-1:0] save_o
);
    logic [4:0] cwp_f;
    assign cwp_f = 5'(cwp_i);

    always_comb begin
        save_o        = '0;
        save_o[42:40] = gl_i;
        save_o[39:32] = ccr_i;
        save_o[31:24] = asi_i;
        save_o[20:8]  = psw_i;
        save_o[4:0]   = cwp_f;
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int ADDR_W       = 64,
    parameter int NWIN         = 8,
    parameter int TL_W         = 3,
    parameter int MAX_TL       = 6,
    parameter int MAX_GL       = 2,
    parameter int HPS_W        = 12,
    parameter int HND_SLOTS    = 32,
    parameter int INSN_BYTES   = 4,
    parameter logic [ADDR_W-1:0] HANDLER_BASE = ADDR_W'(64'h0000_0000_1000_0000),
    localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic [TT_W-1:0]   tt_i,
    input  logic [TL_W-1:0]   tl_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] npc_i,
    input  logic [PSW_W-1:0]  psw_i,
    input  logic [HPS_W-1:0]  hpsw_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [ASI_W-1:0]  asi_i,
    input  logic [CWP_W-1:0]  cwp_i,
    input  logic [CWP_W-1:0]  cansave_i,
    input  logic [GL_W-1:0]   gl_i,
    output logic              wr_o,
    output logic [TL_W-1:0]   tl_o,
    output logic [SAVE_W-1:0] tstate_o,
    output logic [ADDR_W-1:0] tpc_o,
    output logic [ADDR_W-1:0] tnpc_o,
    output logic [HPS_W-1:0]  htstate_o,
    output logic [TT_W-1:0]   tt_o,
    output logic [PSW_W-1:0]  psw_o,
    output logic [GL_W-1:0]   gl_o,
    output logic [CWP_W-1:0]  cwp_o,
    output logic              redir_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o,
    output logic [ADDR_W-1:0] nnpc_o,
    output logic              err_o
);
    localparam logic [TL_W-1:0]   TL_CAP     = TL_W'(MAX_TL);
    localparam logic [GL_W-1:0]   GL_CAP     = GL_W'(MAX_GL);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] FILL_BASE  = HANDLER_BASE;
    localparam logic [ADDR_W-1:0] SPILL_BASE = HANDLER_BASE + ADDR_W'(HND_SLOTS * INSN_BYTES);

    guard_state_e state_q, state_d;
    win_kind_e    kind;
    logic         tl_room, take;
    logic [CWP_W-1:0]  cwp_next;
    logic [PSW_W-1:0]  psw_next;
    logic [SAVE_W-1:0] save_word;
    logic [GL_W-1:0]   gl_next;
    logic [ADDR_W-1:0] hbase;

    assign kind    = classify_tt(tt_i);
    assign tl_room = (tl_i < TL_CAP);
    assign gl_next = (gl_i >= GL_CAP) ? GL_CAP : gl_i + GL_W'(1);
    assign hbase   = (kind == WK_SPILL) ? SPILL_BASE : FILL_BASE;

    trap_win_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
        .kind_i   (kind),
        .cwp_i    (cwp_i),
        .cansave_i(cansave_i),
        .cwp_o    (cwp_next)
    );

    trap_psw_xform u_psw (
        .psw_i(psw_i),
        .psw_o(psw_next)
    );

    trap_save_pack #(.CWP_W(CWP_W)) u_pack (
        .gl_i  (gl_i),
        .ccr_i (ccr_i),
        .asi_i (asi_i),
        .psw_i (psw_i),
        .cwp_i (cwp_i),
        .save_o(save_word)
    );

    // guard state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (trap_i && tl_room)  take    = 1'b1;       // take
                else if (trap_i)        state_d = ST_FAULT;   // overflow
            end
            ST_FAULT: state_d = ST_FAULT;                     // hold
            default:  state_d = ST_FAULT;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_o      <= 1'b0;
            redir_o   <= 1'b0;
            err_o     <= 1'b0;
            tl_o      <= '0;
            cwp_o     <= '0;
            tstate_o  <= '0;
            tpc_o     <= '0;
            tnpc_o    <= '0;
            htstate_o <= '0;
            tt_o      <= '0;
            psw_o     <= '0;
            gl_o      <= '0;
            pc_o      <= '0;
            npc_o     <= '0;
            nnpc_o    <= '0;
        end else begin
            wr_o    <= take;
            redir_o <= take && (kind == WK_SPILL || kind == WK_FILL);
            err_o   <= (state_d == ST_FAULT);
            if (take) begin
                tl_o      <= tl_i + TL_W'(1);
                tstate_o  <= save_word;
                tpc_o     <= pc_i;
                tnpc_o    <= npc_i;
                htstate_o <= hpsw_i;
                tt_o      <= tt_i;
                psw_o     <= psw_next;
                gl_o      <= gl_next;
                cwp_o     <= cwp_next;
                if (kind == WK_SPILL || kind == WK_FILL) begin
                    pc_o   <= hbase;
                    npc_o  <= hbase + STEP;
                    nnpc_o <= hbase + STEP + STEP;
                end
            end
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int NWIN       = 8,
    parameter int TL_W       = 3,
    parameter int MAX_TL     = 6,
    parameter int MAX_GL     = 2,
    parameter int INSN_BYTES = 4,
    localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_i,
    input logic [TL_W-1:0]   tl_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              wr_o,
    input logic [TL_W-1:0]   tl_o,
    input logic [ADDR_W-1:0] tpc_o,
    input logic [PSW_W-1:0]  psw_o,
    input logic [GL_W-1:0]   gl_o,
    input logic [CWP_W-1:0]  cwp_o,
    input logic              redir_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic [ADDR_W-1:0] nnpc_o,
    input logic              err_o
);
    localparam logic [TL_W-1:0]   TL_CAP = TL_W'(MAX_TL);
    localparam logic [GL_W-1:0]   GL_CAP = GL_W'(MAX_GL);
    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(INSN_BYTES);
    localparam logic [CWP_W:0]    NW     = (CWP_W+1)'(NWIN);

    a_r1_tl_step: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_i && !err_o && tl_i < TL_CAP) |=> (wr_o && tl_o == $past(tl_i) + TL_W'(1)));

    a_r3_saved_pc: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> tpc_o == $past(pc_i));

    a_r4_psw_priv: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (psw_o[4] && !psw_o[3] && psw_o[2] && !psw_o[1] && psw_o[9] == psw_o[8]));

    a_r5_gl_cap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> gl_o <= GL_CAP);

    a_r6_cwp_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> {1'b0, cwp_o} < NW);

    a_r10_redir_seq: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (wr_o && npc_o == pc_o + STEP && nnpc_o == pc_o + STEP + STEP));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !wr_o);

    a_r11_tl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && $past(err_o)) |-> $stable(tl_o));
endmodule

bind trap_entry_unit trap_entry_chk #(
    .ADDR_W(ADDR_W), .NWIN(NWIN), .TL_W(TL_W), .MAX_TL(MAX_TL),
    .MAX_GL(MAX_GL), .INSN_BYTES(INSN_BYTES)
) i_chk (.*);

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 64;
    localparam int NWIN   = 6;
    localparam int TL_W   = 3;
    localparam int MAX_TL = 4;
    localparam int MAX_GL = 3;
    localparam int HPS_W  = 12;
    localparam int CWP_W  = 3;
    localparam logic [63:0] BASE = 64'h0000_0000_2000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_i = 1'b0;
    logic [8:0]  tt_i = '0;
    logic [TL_W-1:0] tl_i = '0;
    logic [63:0] pc_i = '0, npc_i = '0;
    logic [12:0] psw_i = '0;
    logic [HPS_W-1:0] hpsw_i = '0;
    logic [7:0]  ccr_i = '0, asi_i = '0;
    logic [CWP_W-1:0] cwp_i = '0, cansave_i = '0;
    logic [2:0]  gl_i = '0;
    logic wr_o, redir_o, err_o;
    logic [TL_W-1:0] tl_o;
    logic [63:0] tstate_o, tpc_o, tnpc_o, pc_o, npc_o, nnpc_o;
    logic [HPS_W-1:0] htstate_o;
    logic [8:0] tt_o;
    logic [12:0] psw_o;
    logic [2:0] gl_o;
    logic [CWP_W-1:0] cwp_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit #(.ADDR_W(ADDR_W), .NWIN(NWIN), .TL_W(TL_W), .MAX_TL(MAX_TL),
        .MAX_GL(MAX_GL), .HPS_W(HPS_W), .HANDLER_BASE(BASE)) i_trap_entry_unit (
        .clk, .rst_n, .trap_i, .tt_i, .tl_i, .pc_i, .npc_i, .psw_i, .hpsw_i,
        .ccr_i, .asi_i, .cwp_i, .cansave_i, .gl_i, .wr_o, .tl_o, .tstate_o,
        .tpc_o, .tnpc_o, .htstate_o, .tt_o, .psw_o, .gl_o, .cwp_o, .redir_o,
        .pc_o, .npc_o, .nnpc_o, .err_o);

    typedef struct {
        bit wr; bit err; bit redir;
        logic [TL_W-1:0] tl; logic [63:0] tstate, tpc, tnpc, pc, npc, nnpc;
        logic [HPS_W-1:0] hts; logic [8:0] tt; logic [12:0] psw;
        logic [2:0] gl; logic [CWP_W-1:0] cwp;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0, n_err = 0, seq = 0;
    bit model_err = 0;
    logic [TL_W-1:0] last_tl = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        trap_i = 1'b0;
    endtask

    // driver: applies a strobe and pushes the expected result
    task automatic strobe(input logic [8:0] tt, input int tl, input int cwp, input int cs,
                          input int gl, input logic [12:0] psw);
        exp_t e;
        int c;
        @(negedge clk);
        seq++;
        tt_i = tt; tl_i = TL_W'(tl); cwp_i = CWP_W'(cwp); cansave_i = CWP_W'(cs);
        gl_i = 3'(gl); psw_i = psw;
        pc_i = 64'h0000_0040_0000_0000 + 64'(seq * 16);
        npc_i = pc_i + 64'd4;
        hpsw_i = HPS_W'(12'h5A0 ^ seq);
        ccr_i = 8'(8'hC3 + seq); asi_i = 8'(8'h80 | seq);
        trap_i = 1'b1;
        e = '{default: '0};
        if (model_err || tl >= MAX_TL) begin
            model_err = 1; e.wr = 0; e.err = 1; e.tl = last_tl;
        end else begin
            e.wr = 1; e.err = 0;
            e.tl = TL_W'(tl + 1); last_tl = e.tl;
            e.tstate = '0;
            e.tstate[42:40] = 3'(gl); e.tstate[39:32] = ccr_i; e.tstate[31:24] = asi_i;
            e.tstate[20:8] = psw; e.tstate[4:0] = 5'(cwp);
            e.tpc = pc_i; e.tnpc = npc_i; e.hts = hpsw_i; e.tt = tt;
            e.psw = psw; e.psw[4] = 1; e.psw[3] = 0; e.psw[2] = 1; e.psw[1] = 0; e.psw[9] = psw[8];
            e.gl = 3'((gl + 1 > MAX_GL) ? MAX_GL : gl + 1);
            if (tt == 9'h024) c = (cwp + 1) % NWIN;
            else if (tt >= 9'h080 && tt <= 9'h0BF) c = (cwp + cs + 2) % NWIN;
            else if (tt >= 9'h0C0 && tt <= 9'h0FF) c = (cwp + NWIN - 1) % NWIN;
            else c = cwp;
            e.cwp = CWP_W'(c);
            e.redir = (tt >= 9'h080 && tt <= 9'h0FF);
            e.pc = (tt >= 9'h080 && tt <= 9'h0BF) ? BASE + 64'd128 : BASE;
            e.npc = e.pc + 64'd4; e.nnpc = e.pc + 64'd8;
        end
        exp_q.push_back(e);
    endtask

    // monitor: compares one cycle after each strobe edge
    initial begin
        forever begin
            bit fired;
            @(posedge clk);
            fired = rst_n && trap_i;
            #1;
            if (fired) begin
                if (exp_q.size() == 0) chk(0, "scoreboard empty", 0, 1);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(wr_o == e.wr, "R1/R11 wr_o", 64'(wr_o), 64'(e.wr));
                    chk(err_o == e.err, "R11 err_o", 64'(err_o), 64'(e.err));
                    chk(tl_o == e.tl, "R1/R11 tl_o", 64'(tl_o), 64'(e.tl));
                    if (e.wr) begin
                        chk(tstate_o == e.tstate, "R2 tstate_o", tstate_o, e.tstate);
                        chk(tpc_o == e.tpc && tnpc_o == e.tnpc, "R3 tpc_o/tnpc_o", tpc_o ^ tnpc_o, e.tpc ^ e.tnpc);
                        chk(htstate_o == e.hts && tt_o == e.tt, "R3 htstate_o/tt_o", {htstate_o, tt_o}, {e.hts, e.tt});
                        chk(psw_o == e.psw, "R4 psw_o", 64'(psw_o), 64'(e.psw));
                        chk(gl_o == e.gl, "R5 gl_o", 64'(gl_o), 64'(e.gl));
                        chk(cwp_o == e.cwp, "R6/R7/R8/R9 cwp_o", 64'(cwp_o), 64'(e.cwp));
                        chk(redir_o == e.redir, "R9/R10 redir_o", 64'(redir_o), 64'(e.redir));
                        if (e.redir)
                            chk(pc_o == e.pc && npc_o == e.npc && nnpc_o == e.nnpc,
                                "R10 pc_o", pc_o, e.pc);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        chk(0, "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!wr_o && !redir_o && !err_o, "R12 flags after reset", {wr_o, redir_o, err_o}, 0);
        chk(tl_o == 0 && cwp_o == 0, "R12 tl_o/cwp_o after reset", {tl_o, cwp_o}, 0);

        strobe(9'h024, 0, 5, 1, 0, 13'h0100); idle();    // R6 wrap 5 -> 0
        strobe(9'h024, 1, 2, 1, 1, 13'h0000); idle();    // R6 2 -> 3
        strobe(9'h080, 2, 5, 4, 2, 13'h1FFF); idle();    // R7 wrap 11 mod 6 = 5, R10 spill base
        strobe(9'h0BF, 0, 1, 0, 3, 13'h0A5A); idle();    // R7 1 -> 3, R5 saturate
        strobe(9'h0C0, 3, 0, 2, 2, 13'h0155);            // R8 wrap 0 -> 5, R10 fill base
        strobe(9'h0FF, 1, 3, 2, 1, 13'h1EAA);            // R8 back-to-back 3 -> 2
        idle();
        strobe(9'h07F, 2, 4, 3, 0, 13'h0333); idle();    // R9 unchanged
        strobe(9'h100, 0, 2, 3, 1, 13'h1100); idle();    // R9 outside fill range
        strobe(9'h023, 3, 1, 0, 3, 13'h00FF); idle();    // R9 adjacent to clean type
        strobe(9'h090, 4, 2, 1, 0, 13'h0000); idle();    // R11 overflow
        repeat (2) @(negedge clk);
        chk(err_o == 1'b1, "R11 err_o sticky", 64'(err_o), 1);
        strobe(9'h024, 1, 0, 0, 0, 13'h0000); idle();    // R11 ignored after fault
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule